// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counting timer whose advance is gated by a single-cycle tick input, standing in for an instruction-cycle strobe at a quarter of the system clock. The tick first passes through a selectable prescaler (divide by 1, 4 or 16). Each prescaled step increments the count, except when the count already equals a programmable 8-bit period value. In that case the count returns to zero and a one-cycle match event is produced.

The match event is exported unscaled on its own pin, so that a PWM or a serial shift clock can use it as a time base. It also feeds a 4-bit postscaler that divides the match rate by 1 to 16. Each postscaler rollover sets a sticky interrupt flag. The flag drives the interrupt output only while its enable bit is set.

Software reaches the block through a small register port: a write strobe, a 2-bit address, 8-bit write data and combinational 8-bit read data. The address map is 0 for control, 1 for the count, 2 for the period and 3 for the flag and enable.

Top module: `period_timer`

## Requirements
- R1: Address 1 reads and writes the count and address 2 reads and writes the period. A written count is seen on the next read, and counting continues from the written value.
- R2: The prescale field, control bits 1:0, sets the ratio of ticks to count steps: 00 gives 1, 01 gives 4, and 10 or 11 gives 16.
- R3: On a step taken while the count equals the period, the count becomes 0 and match_pulse is high for exactly the following cycle. On any other step the count increases by one, wrapping from 255 to 0.
- R4: The postscale field, control bits 6:3, holding value N, sets the interrupt flag on every (N+1)-th match. The flag is set in the same cycle that match_pulse is high.
- R5: Control bit 2 is the run bit. Control bit 7 always reads 0, whatever value was written to it.
- R6: While the run bit is 0, ticks are ignored: the count, the prescale count and the postscale count all hold.
- R7: A write to address 0 or address 1 resets the prescale and postscale counts to zero. No step is taken in that cycle.
- R8: The interrupt flag is bit 0 of address 3. It stays set until software writes 0 to it. When a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R9: Bit 1 of address 3 is the interrupt enable. irq is high exactly when both the flag and the enable are 1.
- R10: After reset the count reads 0x00, the period 0xFF, the control 0x00 and address 3 reads 0x00. match_pulse and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-cycle tick (clock enable) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 period, 3 flag/enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request (flag AND enable) |
| match_pulse | output | 1 | Unscaled one-cycle period-match pulse |

## Verification
The tick input is driven in four patterns: held low, held high, every fourth cycle and pseudo-random. The high and quarter-rate patterns separate the three prescale ratios from one another. The random pattern exposes any step that is taken on a wrong tick.

Periods of 0, 2, 5 and values below the current count are used. A period of 0 makes the count match on every step. A period below the current count forces a wrap through 255.

Several postscale values are run with control and count writes landing mid-prescale. This shows whether those writes clear the intermediate counts. Flag clears are issued while matches arrive on every cycle, which shows whether the hardware set wins over the software clear.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_IRQ    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       step
);
  logic [PRE_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = PRE_W'(3);
      default: lim = PRE_W'(15);
    endcase
  end

  assign step = run && tick && !clr && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (run && tick) cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr || (run && tick))  cnt_q <= cnt_d;
  end

  // R7: a clearing write leaves the prescale count at zero
  p_pre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R6: without run the prescale count holds
  p_pre_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              match_ev,
  output logic              match_q
);
  logic [DATA_W-1:0] cnt_q, cnt_d;

  assign match_ev = step && (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (match_ev) cnt_d = '0;
    else if (step)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_ev;
      if (load || step) cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R3: matching step returns the count to zero and pulses the output
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == period) |=> (cnt_q == '0 && match_q));
  // R6: no step and no load means the count holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              clr,
  input  logic [POST_W-1:0] sel,
  output logic              hit
);
  logic [POST_W-1:0] cnt_q, cnt_d;

  assign hit = ev && !clr && (cnt_q == sel);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (ev) cnt_d = (cnt_q == sel) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr || ev) cnt_q <= cnt_d;
  end

  // R7: clearing write resets the postscale count
  p_post_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              match_pulse
);
  localparam int CTRL_W = 7;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] period_q, period_d;
  logic              flag_q, flag_d, en_q, en_d;

  logic              wr_ctrl, wr_count, wr_period, wr_irq, clr_counts;
  logic              run;
  logic [1:0]        pre_sel;
  logic [POST_W-1:0] post_sel;
  logic              step, match_ev, hw_set;
  logic [DATA_W-1:0] count;

  assign wr_ctrl    = bus_wr && (bus_addr == SEL_CTRL);
  assign wr_count   = bus_wr && (bus_addr == SEL_COUNT);
  assign wr_period  = bus_wr && (bus_addr == SEL_PERIOD);
  assign wr_irq     = bus_wr && (bus_addr == SEL_IRQ);
  assign clr_counts = wr_ctrl || wr_count;

  assign post_sel = ctrl_q[6:3];
  assign run      = ctrl_q[2];
  assign pre_sel  = ctrl_q[1:0];

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .tick(tick_en), .run(run),
    .sel(pre_sel), .clr(clr_counts), .step(step)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .step(step), .load(wr_count),
    .load_val(bus_wdata), .period(period_q), .count(count),
    .match_ev(match_ev), .match_q(match_pulse)
  );

  tmr_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_ni), .ev(match_ev), .clr(clr_counts),
    .sel(post_sel), .hit(hw_set)
  );

  always_comb begin
    ctrl_d   = wr_ctrl   ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    period_d = wr_period ? bus_wdata : period_q;
    en_d     = wr_irq    ? bus_wdata[1] : en_q;
    flag_d   = hw_set || (wr_irq ? bus_wdata[0] : flag_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_d;
      if (wr_period) period_q <= period_d;
      if (wr_irq)    en_q     <= en_d;
      if (wr_irq || hw_set) flag_q <= flag_d;
    end
  end

  always_comb begin
    case (bus_addr)
      SEL_CTRL:   bus_rdata = {1'b0, ctrl_q};
      SEL_COUNT:  bus_rdata = count;
      SEL_PERIOD: bus_rdata = period_q;
      default:    bus_rdata = {{(DATA_W-2){1'b0}}, en_q, flag_q};
    endcase
  end

  assign irq = flag_q && en_q;

  // R8: a hardware set always lands, even against a clear
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    hw_set |=> flag_q);
  // R4: the flag rises only together with a match pulse
  p_flag_match_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(flag_q) && !$past(wr_irq)) |-> match_pulse);
  // R9: irq needs the enable
  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> en_q);
  // R5: control bit 7 never reads back as one
  p_ctrl_b7_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr == SEL_CTRL) |-> !bus_rdata[7]);
endmodule

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, match_pulse;

  int total = 0, bad = 0, wd = 0;
  int tick_mode = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  period_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .match_pulse(match_pulse)
  );

  // reference model
  int m_cnt, m_per, m_ctrl, m_pre, m_post, m_flag, m_en, m_match;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 255; m_ctrl = 0; m_pre = 0; m_post = 0;
      m_flag = 0; m_en = 0; m_match = 0;
    end else begin
      int lim, psel, on, sel;
      bit clr, stp, ev, hs;
      clr  = bus_wr && (bus_addr == 0 || bus_addr == 1);
      on   = (m_ctrl >> 2) & 1;
      sel  = m_ctrl & 3;
      psel = (m_ctrl >> 3) & 15;
      lim  = (sel == 0) ? 0 : (sel == 1) ? 3 : 15;
      stp  = on && tick_en && !clr && (m_pre == lim);
      ev   = stp && (m_cnt == m_per);
      hs   = ev && (m_post == psel);
      if (clr) m_pre = 0;
      else if (on && tick_en) m_pre = (m_pre == lim) ? 0 : m_pre + 1;
      if (clr) m_post = 0;
      else if (ev) m_post = (m_post == psel) ? 0 : m_post + 1;
      if (bus_wr && bus_addr == 1) m_cnt = bus_wdata;
      else if (ev) m_cnt = 0;
      else if (stp) m_cnt = (m_cnt + 1) % 256;
      if (bus_wr && bus_addr == 3) begin
        m_flag = bus_wdata[0];
        m_en = bus_wdata[1];
      end
      if (hs) m_flag = 1;
      if (bus_wr && bus_addr == 2) m_per = bus_wdata;
      if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata & 8'h7F;
      m_match = ev;
    end
  end

  function automatic int exp_rdata(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_per;
      default: return m_en * 2 + m_flag;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && cyc > 3) begin
      check(cur_req, "rdata", int'(bus_rdata), exp_rdata(int'(bus_addr)));
      check("R3", "match_pulse", int'(match_pulse), m_match);
      check("R9", "irq", int'(irq), m_flag & m_en);
    end
  end

  // tick generation
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: tick_en = 1'b0;
      1: tick_en = 1'b1;
      2: tick_en = (cyc % 4 == 0);
      default: tick_en = lfsr[0];
    endcase
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input int a, input int exp, input string req);
    @(negedge clk);
    bus_addr = 2'(a);
    @(posedge clk); #2;
    check(req, "read", int'(bus_rdata), exp);
  endtask

  task automatic run_view(input int a, input int n);
    @(negedge clk);
    bus_addr = 2'(a);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    cur_req = "R10";
    check("R10", "match_pulse", int'(match_pulse), 0);
    check("R10", "irq", int'(irq), 0);
    rd_check(0, 0, "R10");
    rd_check(1, 0, "R10");
    rd_check(2, 255, "R10");
    rd_check(3, 0, "R10");

    // R1 count/period access
    cur_req = "R1";
    wr_reg(1, 8'h5A); rd_check(1, 8'h5A, "R1");
    wr_reg(2, 8'h33); rd_check(2, 8'h33, "R1");
    // R5 control bit 7 reads zero
    cur_req = "R5";
    wr_reg(0, 8'hFB); rd_check(0, 8'h7B, "R5");
    wr_reg(0, 8'h00);

    // R2/R3 prescale ratios with period 5
    cur_req = "R3";
    wr_reg(1, 0); wr_reg(2, 5);
    tick_mode = 1;
    wr_reg(0, 8'h04); run_view(1, 40);
    cur_req = "R2";
    wr_reg(0, 8'h05); run_view(1, 80);
    wr_reg(0, 8'h06); run_view(1, 200);
    wr_reg(0, 8'h07); run_view(1, 100);
    tick_mode = 2;
    wr_reg(0, 8'h05); run_view(1, 120);
    // R3 period below count forces a wrap through 255
    cur_req = "R3";
    tick_mode = 1;
    wr_reg(0, 8'h04); wr_reg(1, 8'hF0); wr_reg(2, 3); run_view(1, 60);

    // R4/R9 postscaler and interrupt enable
    cur_req = "R4";
    wr_reg(2, 2); wr_reg(3, 8'h02);
    wr_reg(0, (3 << 3) | 4); run_view(3, 60);
    wr_reg(3, 8'h02); wr_reg(0, (15 << 3) | 4); run_view(3, 120);
    cur_req = "R9";
    wr_reg(3, 8'h00); wr_reg(0, (1 << 3) | 4); run_view(3, 30);

    // R8 hardware set beats software clear: match every cycle
    cur_req = "R8";
    wr_reg(2, 0); wr_reg(0, 8'h04); run_view(3, 5);
    wr_reg(3, 8'h02);
    rd_check(3, 3, "R8");
    check("R8", "irq", int'(irq), 1);
    // R8 clear sticks when no match arrives
    wr_reg(0, 8'h00); wr_reg(3, 8'h02); rd_check(3, 2, "R8");
    run_view(3, 10);
    rd_check(3, 2, "R8");

    // R6 run bit clear: ticks ignored
    cur_req = "R6";
    wr_reg(2, 100); wr_reg(1, 7); run_view(1, 30);
    rd_check(1, 7, "R6");
    check("R6", "match_pulse", int'(match_pulse), 0);

    // R7 mid-prescale writes clear counts, random ticks
    cur_req = "R7";
    tick_mode = 3;
    wr_reg(2, 3); wr_reg(3, 8'h02);
    wr_reg(0, (2 << 3) | 6); run_view(1, 37);
    wr_reg(0, (2 << 3) | 6); run_view(1, 9);
    wr_reg(1, 2); run_view(1, 50);
    wr_reg(0, (1 << 3) | 5); run_view(3, 41);
    wr_reg(1, 0); run_view(3, 300);
    for (int i = 0; i < 20; i++) begin
      wr_reg(3, 8'h02); run_view(1, 13 + i);
    end
    // R2 random ticks at each ratio
    cur_req = "R2";
    wr_reg(2, 1); wr_reg(0, 8'h04); run_view(1, 100);
    wr_reg(0, 8'h05); run_view(1, 100);

    tick_mode = 0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule